// File: doc/BRIEF.md
# Bit-Slip Serial-to-Parallel Deserializer

This block turns a serial NRZ stream, one bit per clock, into parallel words of `WORD_W` bits (four by default). The earliest bit of each word lands on `q[0]` and later bits land on higher indices. Two serial inputs feed a selector, so a loopback path can replace the normal data path for testing. The selected bit also leaves the block one clock later on a serial output.

A free-running counter sets the word boundaries. Two of its bits are brought out as divided clocks: one with a period of `WORD_W` clocks and one with a period of `2*WORD_W` clocks. A mode input sets how often the parallel register updates. In single mode it updates once per word period. In pair mode it updates once per two word periods, for cascading two blocks.

A request on the sync input first passes through a synchronizer and a rising-edge detector. It then makes the counter hold for one clock while data keeps shifting. This moves the word boundary one bit later in the stream. A synchronous active-high reset clears the counter and all registers.

Top module: `bitslip_deser`

## Requirements
- R1: Inside a captured word, the bit presented first sits on `q[0]` and each later bit sits one index higher. With the default width, `q[3]` holds the last bit.
- R2: `clk_div_word` equals counter bit 1 and `clk_div_pair` equals counter bit 2 of a 3-bit counter that counts 0..7 and advances once per clock. They therefore have periods of 4 and 8 clocks when no skip occurs.
- R3: With `sel_b` = 0 the shift path takes `din_a`. With `sel_b` = 1 it takes `din_b`.
- R4: `sync_req` is sampled on each clock. When it is first sampled high at edge e after being sampled low, the counter holds its value at edge e+2 and no word loads at that edge. The next word boundary therefore falls one bit later, and a bit that was on `q[n]` moves to `q[n-1]`.
- R5: Each low-to-high change of `sync_req` produces exactly one skip. Holding it high for any number of clocks adds no further skip.
- R6: With `mode8` = 0, `q` loads when the counter's two low bits are both 1. With `mode8` = 1, `q` loads only when the counter reads 7. Each load takes the four most recent serial bits, including the bit present at the loading edge.
- R7: Reset clears the counter, the divided clocks, the serial output and the shift register. `q` reads 0 until the first load after reset.
- R8: `sout` equals the selected serial input delayed by one clock.
- R9: Between loads, `q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| din_a | input | 1 | Serial data input A |
| din_b | input | 1 | Serial data input B (loopback) |
| sel_b | input | 1 | 1 selects din_b, 0 selects din_a |
| mode8 | input | 1 | 1 selects the pair (8-clock) update rate |
| sync_req | input | 1 | Word-alignment slip request |
| sout | output | 1 | Selected serial input, registered |
| q | output | WORD_W | Parallel word |
| clk_div_word | output | 1 | Clock divided by WORD_W |
| clk_div_pair | output | 1 | Clock divided by 2*WORD_W |

## Verification
The assertions check three things on every clock. First, a skip lasts a single cycle and freezes both divided clocks. Second, `q` does not move outside a load. Third, `sout` follows the selected input by one clock.

Only the bench's scenarios can show the rest, because these depend on the data history. They are the placement of bits in a word, the one-bit boundary move after a short sync pulse, the single move under a long-held pulse, the 8-clock update rate, and the return to zero after a reset in mid-run. A behavioural model replays every clock of these scenarios alongside the design.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef enum logic {
    RATE_SINGLE = 1'b0,
    RATE_PAIR   = 1'b1
  } rate_t;

  function automatic int cnt_bits(input int word_w);
    return $clog2(word_w) + 1;
  endfunction
endpackage

// File: rtl/bsd_sync_edge.sv
module bsd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_evt
);
  // pipe[0..STAGES-1] synchronize; pipe[STAGES] remembers the previous level
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign rise_evt = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/bsd_divider.sv
module bsd_divider #(
  parameter int WORD_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic clk_word,
  output logic clk_pair,
  output logic tc_word,
  output logic tc_pair
);
  localparam int CNT_W = bsd_pkg::cnt_bits(WORD_W);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (!hold) cnt <= cnt + 1'b1;
  end

  assign clk_word = cnt[CNT_W-2];
  assign clk_pair = cnt[CNT_W-1];
  assign tc_word  = (&cnt[CNT_W-2:0]) & ~hold;
  assign tc_pair  = (&cnt) & ~hold;
endmodule

// File: rtl/bsd_shifter.sv
module bsd_shifter #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din_a,
  input  logic              din_b,
  input  logic              sel_b,
  output logic [WORD_W-1:0] word_next,
  output logic              sout
);
  logic              ser_bit;
  logic [WORD_W-1:0] sh;

  assign ser_bit   = sel_b ? din_b : din_a;
  // newest bit enters at the top, so the oldest one ends up at index 0
  assign word_next = {ser_bit, sh[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      sout <= 1'b0;
    end else begin
      sh   <= word_next;
      sout <= ser_bit;
    end
  end
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din_a,
  input  logic              din_b,
  input  logic              sel_b,
  input  logic              mode8,
  input  logic              sync_req,
  output logic              sout,
  output logic [WORD_W-1:0] q,
  output logic              clk_div_word,
  output logic              clk_div_pair
);
  import bsd_pkg::*;

  logic              skip_evt;
  logic              tc_word;
  logic              tc_pair;
  logic              word_load;
  logic [WORD_W-1:0] word_next;
  rate_t             rate;

  bsd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (sync_req),
    .rise_evt (skip_evt)
  );

  bsd_divider #(.WORD_W(WORD_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .hold     (skip_evt),
    .clk_word (clk_div_word),
    .clk_pair (clk_div_pair),
    .tc_word  (tc_word),
    .tc_pair  (tc_pair)
  );

  bsd_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .din_a     (din_a),
    .din_b     (din_b),
    .sel_b     (sel_b),
    .word_next (word_next),
    .sout      (sout)
  );

  assign rate      = rate_t'(mode8);
  assign word_load = (rate == RATE_PAIR) ? tc_pair : tc_word;

  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (word_load) q <= word_next;
  end
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker #(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              din_a,
  input logic              din_b,
  input logic              sel_b,
  input logic              sout,
  input logic [WORD_W-1:0] q,
  input logic              clk_div_word,
  input logic              clk_div_pair,
  input logic              skip,
  input logic              load
);
  // R4
  skip_freezes_div_chk: assert property (@(posedge clk) disable iff (rst)
    skip |=> ($stable(clk_div_word) && $stable(clk_div_pair)));

  // R5
  single_skip_chk: assert property (@(posedge clk) disable iff (rst)
    skip |=> !skip);

  // R9
  hold_between_loads_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

  // R8
  sout_delay_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sout == $past(sel_b ? din_b : din_a)));

  // R6
  no_load_on_skip_chk: assert property (@(posedge clk) disable iff (rst)
    skip |-> !load);
endmodule

bind bitslip_deser bsd_checker #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .din_a        (din_a),
  .din_b        (din_b),
  .sel_b        (sel_b),
  .sout         (sout),
  .q            (q),
  .clk_div_word (clk_div_word),
  .clk_div_pair (clk_div_pair),
  .skip         (skip_evt),
  .load         (word_load)
);

// File: tb/sim_bitslip_deser.sv
`timescale 1ns/1ps
module sim_bitslip_deser;
  logic clk = 1'b0;
  logic rst, din_a, din_b, sel_b, mode8, sync_req;
  logic sout, clk_div_word, clk_div_pair;
  logic [3:0] q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bitslip_deser u0 (
    .clk(clk), .rst(rst), .din_a(din_a), .din_b(din_b), .sel_b(sel_b),
    .mode8(mode8), .sync_req(sync_req), .sout(sout), .q(q),
    .clk_div_word(clk_div_word), .clk_div_pair(clk_div_pair)
  );

  // behavioural reference model
  int   m_cnt;
  logic m_q [4];
  logic m_sout;
  bit   bitq[$];
  bit   syncq[$];

  always @(posedge clk) begin
    bit ser, s2, s3, skip, ld;
    int n;
    if (rst) begin
      m_cnt = 0; m_sout = 0;
      for (int k = 0; k < 4; k++) m_q[k] = 0;
      bitq = '{0, 0, 0, 0};
      syncq.delete();
    end else begin
      ser = sel_b ? din_b : din_a;
      n = syncq.size();
      s2 = (n >= 2) ? syncq[n-2] : 1'b0;
      s3 = (n >= 3) ? syncq[n-3] : 1'b0;
      skip = s2 && !s3;
      syncq.push_back(sync_req);
      if (syncq.size() > 3) void'(syncq.pop_front());
      ld = !skip && (mode8 ? (m_cnt == 7) : (m_cnt % 4 == 3));
      bitq.push_back(ser);
      if (bitq.size() > 4) void'(bitq.pop_front());
      if (ld) for (int k = 0; k < 4; k++) m_q[k] = bitq[k];
      if (!skip) m_cnt = (m_cnt + 1) % 8;
      m_sout = ser;
    end
  end

  function automatic logic [3:0] mq();
    return {m_q[3], m_q[2], m_q[1], m_q[0]};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against model at negedge (model already updated at posedge)
  always @(negedge clk) if (!done && !rst) begin
    chk("R1 R6 R9 q", q, mq());
    chk("R8 sout", {3'b0, sout}, {3'b0, m_sout});
    chk("R2 clk_div_word", {3'b0, clk_div_word}, {3'b0, 1'(m_cnt[1])});
    chk("R2 clk_div_pair", {3'b0, clk_div_pair}, {3'b0, 1'(m_cnt[2])});
  end

  bit pat_a [4] = '{1, 0, 0, 0};
  bit pat_b [4] = '{0, 1, 1, 0};
  int t = 0;

  task automatic step(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      #1;
      din_a = pat_a[t % 4];
      din_b = pat_b[t % 4];
      t++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step(3);
    @(negedge clk);
    #2;
    chk("R7 reset q", q, 4'b0000);
    chk("R7 reset clocks", {2'b0, clk_div_pair, clk_div_word}, 4'b0000);
    chk("R7 reset sout", {3'b0, sout}, 4'b0000);
    rst = 1'b0;
    t = 0;
    din_a = pat_a[0]; din_b = pat_b[0]; t = 1;
  endtask

  initial begin
    rst = 1; din_a = 0; din_b = 0; sel_b = 0; mode8 = 0; sync_req = 0;
    do_reset();
    step(2);
    chk("R7 q zero before first load", q, 4'b0000);
    step(14);
    chk("R1 first bit on q0", q, 4'b0001);
    // R4: short pulse, two clocks
    sync_req = 1; step(2); sync_req = 0;
    step(16);
    chk("R4 slip by one bit", q, 4'b1000);
    // R5: long pulse gives a single slip
    sync_req = 1; step(30); sync_req = 0;
    step(12);
    chk("R5 long pulse one slip", q, 4'b0100);
    // R3: loopback input
    sel_b = 1; step(24);
    chk("R3 din_b selected", q, mq());
    sel_b = 0;
    // R6: pair rate
    mode8 = 1; step(40);
    sync_req = 1; step(3); sync_req = 0; step(30);
    mode8 = 0; step(12);
    // R7: mid-run reset
    do_reset();
    step(16);
    chk("R7 realign after reset", q, 4'b0001);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20000 * 10);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule